// File: doc/BRIEF.md
# Binary-to-Decimal Converter with Weighted Slice Tables

This block turns an unsigned binary word into packed decimal digits, four bits per digit. It does not shift the operand through a decimal-adjust chain one bit at a time. Instead it cuts the latched operand into equal slices. For each slice, a constant table held on chip gives the decimal form of that slice's value multiplied by the weight of its bit position. A decimal adder sums these table outputs into a decimal accumulator, one slice per clock, starting with the least significant slice. With a 32-bit operand and byte slices, a conversion takes four accumulation steps. With nibble slices it takes eight.

All table contents are computed while the design is elaborated, so no memory file is needed. The decimal adder works digit by digit. When a digit's binary sum exceeds nine, it adds six to that digit and passes a carry to the next digit up. The digit count is derived from the operand width, giving ten digits for 32 bits.

The sequencer has three states:
- `ST_IDLE` waits for `start`. On a start it latches `bin_in`, clears the accumulator and moves to `ST_ACCUM`.
- `ST_ACCUM` adds one slice weight per clock. After the last slice it moves to `ST_FINISH`.
- `ST_FINISH` raises `done` for one clock and returns to `ST_IDLE`.

Top module: `bin2dec_lut_acc`

## Requirements
- R1: While reset is asserted and after it is released, until the first start, `done` is 0 and `bcd_out` is all zero.
- R2: A `start` sampled high in `ST_IDLE` latches `bin_in` and clears the accumulator, so `bcd_out` reads zero during the following clock.
- R3: Each step in `ST_ACCUM` adds the decimal weight of one slice, lowest slice first. After the first step, `bcd_out` equals the decimal value of the lowest `SLICE_W` bits of the operand.
- R4: After all `IN_W/SLICE_W` steps, `bcd_out` holds the decimal value of the operand. Digit 0 is in bits 3:0, and each higher digit sits four bits further up. For example, 0x000014C6 gives 5318 and 0xFFFFFFFF gives 4294967295.
- R5: `done` is high for exactly one clock, in the cycle that begins `IN_W/SLICE_W` rising edges after the edge that accepted `start`.
- R6: Every four-bit digit of `bcd_out` is at most 9 in every cycle.
- R7: While a conversion is in progress, `start` pulses and changes on `bin_in` are ignored: neither the result nor the timing of `done` changes.
- R8: After `done`, `bcd_out` holds the result unchanged until the next accepted `start`.
- R9: During accumulation no carry leaves the most significant digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a conversion when the block is idle |
| bin_in | input | IN_W (32) | Unsigned binary operand, sampled with `start` |
| done | output | 1 | One-clock pulse marking a finished conversion |
| bcd_out | output | 4*digits (40) | Accumulated decimal digits, digit 0 in the low nibble |

## Verification
The bench builds two copies of the block, both with a 32-bit operand. One uses byte slices (four steps); the other uses nibble slices (eight steps). The byte build exercises the largest tables and the widest step weights. The nibble build exercises the longer step sequence and a different table depth, so the generated tables and the step counter are tested at both sizes. The random operands are mixed with all-ones and near-all-ones values. These operands force carry chains through every digit and push the top digits to their largest values.

// File: rtl/b2d_pkg.sv
package b2d_pkg;

    localparam int MAX_BIN_W = 64;
    localparam int MAX_DIGITS = 20;
    localparam int MAX_BCD_W = 4 * MAX_DIGITS;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_FINISH = 2'd2
    } b2d_state_e;

    // Elaboration-time decimal conversion used to fill the weight tables.
    function automatic logic [MAX_BCD_W-1:0] to_bcd(input logic [MAX_BIN_W-1:0] value);
        logic [MAX_BCD_W-1:0] r;
        r = '0;
        for (int i = MAX_BIN_W - 1; i >= 0; i--) begin
            for (int d = 0; d < MAX_DIGITS; d++) begin
                if (r[4*d +: 4] >= 4'd5)
                    r[4*d +: 4] = r[4*d +: 4] + 4'd3;
            end
            r = {r[MAX_BCD_W-2:0], value[i]};
        end
        return r;
    endfunction

    // Number of decimal digits needed for the largest value of a given width.
    function automatic int dec_digits(input int bits);
        logic [MAX_BIN_W-1:0] m;
        int n;
        m = (bits >= MAX_BIN_W) ? '1 : ((64'd1 << bits) - 64'd1);
        n = 0;
        while (m != 0) begin
            m = m / 64'd10;
            n++;
        end
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/b2d_weight_rom.sv
module b2d_weight_rom #(
    parameter int SLICE_W = 8,
    parameter int SHIFT   = 0,
    parameter int BCD_W   = 40
) (
    input  logic [SLICE_W-1:0] addr,
    output logic [BCD_W-1:0]   weight
);
    localparam int ENTRIES = 1 << SLICE_W;

    logic [BCD_W-1:0] table_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [b2d_pkg::MAX_BCD_W-1:0] FULL_BCD =
            b2d_pkg::to_bcd(64'(e) << SHIFT);
        assign table_q[e] = FULL_BCD[BCD_W-1:0];
    end

    assign weight = table_q[addr];
endmodule

// File: rtl/b2d_decimal_adder.sv
module b2d_decimal_adder #(
    parameter int DIGITS = 10
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    output logic [4*DIGITS-1:0] sum,
    output logic                carry_out
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b0;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] adj;
        always_comb begin
            raw = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'd0, carry[d]};
            adj = (raw > 5'd9) ? (raw + 5'd6) : raw;
        end
        assign sum[4*d +: 4] = adj[3:0];
        assign carry[d+1]    = (raw > 5'd9);
    end

    assign carry_out = carry[DIGITS];
endmodule

// File: rtl/bin2dec_lut_acc.sv
module bin2dec_lut_acc #(
    parameter int IN_W    = 32,
    parameter int SLICE_W = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic [IN_W-1:0]                            bin_in,
    output logic                                       done,
    output logic [4*b2d_pkg::dec_digits(IN_W)-1:0]     bcd_out
);
    import b2d_pkg::*;

    localparam int SLICES = IN_W / SLICE_W;
    localparam int DIGITS = dec_digits(IN_W);
    localparam int BCD_W  = 4 * DIGITS;
    localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLICES - 1);

    b2d_state_e state, state_nx;

    logic [IN_W-1:0]  operand;
    logic [BCD_W-1:0] acc;
    logic [BCD_W-1:0] acc_sum;
    logic             acc_carry;
    logic [IDX_W-1:0] idx;
    logic             busy;
    logic [BCD_W-1:0] slice_weight [SLICES];

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        b2d_weight_rom #(
            .SLICE_W (SLICE_W),
            .SHIFT   (k * SLICE_W),
            .BCD_W   (BCD_W)
        ) u_rom (
            .addr   (operand[k*SLICE_W +: SLICE_W]),
            .weight (slice_weight[k])
        );
    end

    b2d_decimal_adder #(.DIGITS(DIGITS)) u_add (
        .a         (acc),
        .b         (slice_weight[idx]),
        .sum       (acc_sum),
        .carry_out (acc_carry)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ACCUM;
            ST_ACCUM:  if (idx == LAST_IDX) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done = (state == ST_FINISH);
        busy = (state != ST_IDLE);
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            operand <= '0;
            acc     <= '0;
            idx     <= '0;
        end else if (state == ST_IDLE && start) begin
            operand <= bin_in;
            acc     <= '0;
            idx     <= '0;
        end else if (state == ST_ACCUM) begin
            acc <= acc_sum;
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    assign bcd_out = acc;
endmodule

// File: rtl/b2d_checker.sv
module b2d_checker #(
    parameter int BCD_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             carry,
    input logic [BCD_W-1:0] bcd_out
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (bcd_out == '0)); // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(bcd_out)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !carry); // R9

    for (genvar d = 0; d < BCD_W / 4; d++) begin : g_dig
        AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_out[4*d +: 4] <= 4'd9); // R6
    end
endmodule

bind bin2dec_lut_acc b2d_checker #(.BCD_W(BCD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .carry   (acc_carry),
    .bcd_out (bcd_out)
);

// File: tb/test_bin2dec_lut_acc.sv
module test_bin2dec_lut_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_b = 1'b0;
    logic        start_n = 1'b0;
    logic [31:0] bin_in = '0;
    logic        done_b, done_n;
    logic [39:0] bcd_b, bcd_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bin2dec_lut_acc #(.IN_W(32), .SLICE_W(8)) i_bin2dec_lut_acc (
        .clk(clk), .rst_n(rst_n), .start(start_b), .bin_in(bin_in),
        .done(done_b), .bcd_out(bcd_b)
    );

    bin2dec_lut_acc #(.IN_W(32), .SLICE_W(4)) i_bin2dec_lut_acc_nib (
        .clk(clk), .rst_n(rst_n), .start(start_n), .bin_in(bin_in),
        .done(done_n), .bcd_out(bcd_n)
    );

    function automatic logic [39:0] ref_dec(input logic [31:0] v);
        logic [39:0] r;
        logic [63:0] x;
        r = '0;
        x = {32'd0, v};
        for (int d = 0; d < 10; d++) begin
            r[4*d +: 4] = 4'(x % 64'd10);
            x = x / 64'd10;
        end
        return r;
    endfunction

    function automatic bit all_decimal(input logic [39:0] v);
        for (int d = 0; d < 10; d++)
            if (v[4*d +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] cur_bcd(input bit nib);
        return nib ? bcd_n : bcd_b;
    endfunction

    function automatic logic cur_done(input bit nib);
        return nib ? done_n : done_b;
    endfunction

    task automatic set_start(input bit nib, input logic val);
        if (nib) start_n = val;
        else     start_b = val;
    endtask

    task automatic run(input bit nib, input logic [31:0] v, input bit disturb);
        int steps;
        logic [31:0] mask;
        logic [39:0] res;
        steps = nib ? 8 : 4;
        mask  = nib ? 32'h0000_000F : 32'h0000_00FF;
        @(negedge clk);
        bin_in = v;
        set_start(nib, 1'b1);
        @(negedge clk);
        set_start(nib, 1'b0);
        check(cur_bcd(nib) == '0, "R2 clear on start", cur_bcd(nib), '0);
        for (int n = 1; n <= steps + 3; n++) begin
            @(negedge clk);
            set_start(nib, 1'b0);
            if (n == 1) begin
                check(cur_bcd(nib) == ref_dec(v & mask), "R3 first slice", cur_bcd(nib), ref_dec(v & mask));
                if (disturb) begin
                    bin_in = ~v;
                    set_start(nib, 1'b1);
                end
            end
            check(all_decimal(cur_bcd(nib)), "R6 digit range", cur_bcd(nib), '0);
            if (cur_done(nib)) begin
                check(n == steps, "R5 done timing", 40'(n), 40'(steps));
                break;
            end
            if (n == steps + 3)
                check(1'b0, "R5 done missing", 40'(n), 40'(steps));
        end
        res = cur_bcd(nib);
        check(res == ref_dec(v), disturb ? "R7 ignored start/R4 result" : "R4 result", res, ref_dec(v));
        bin_in = 32'h1234_5678;
        @(negedge clk);
        check(cur_done(nib) == 1'b0, "R5 single pulse", 40'(cur_done(nib)), 40'd0);
        repeat (2) @(negedge clk);
        check(cur_bcd(nib) == res, "R8 result held", cur_bcd(nib), res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done_b == 1'b0 && bcd_b == '0, "R1 reset state", bcd_b, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_n == 1'b0 && bcd_n == '0, "R1 after reset", bcd_n, '0);

        for (int s = 0; s < 2; s++) begin
            run(s[0], 32'h0000_14C6, 1'b0);   // R4 example: 5318
            run(s[0], 32'hFFFF_FFFF, 1'b0);   // R9 all ones
            run(s[0], 32'hAABB_CCDD, 1'b0);
            run(s[0], 32'hFFFF_FFAA, 1'b1);   // R7 disturbed
            run(s[0], 32'h0000_0000, 1'b0);
            run(s[0], 32'h3B9A_C9FF, 1'b0);
        end

        void'($urandom(32'd20240611));
        for (int i = 0; i < 60; i++)
            run(i[0], $urandom(), i % 5 == 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule